// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A sixteen-line general-purpose I/O peripheral behind a small memory-mapped register interface. Each line is either an input or an output, as its direction bit selects. An output line drives the value held in the output data register and raises its output-enable. An input line passes through a two-flop synchronizer. A selected transition on an input line can record a sticky status bit. While any status bit is set, a single level interrupt request is raised.

Software programs these registers:

- the output data register;
- the direction register;
- the per-line transition select;
- the interrupt mask;
- the pin-enable register, which gates the value read back from the input data register.

Status bits are cleared by writing ones to them. Registers are written on a clock edge while the write strobe is high. Reads are combinational from the address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the register reads are as follows: input data 0x0000, output data 0xFFFF, direction 0xFFFF, transition select 0xFFFF, mask 0xFFFF, status 0x0000 and pin enable 0xFFFF. After reset `pin_oe` is 0 and `irq` is 0.
- R2: Offset 0x08 holds direction, where a bit of 1 means input and a bit of 0 means output. Offset 0x04 holds output data. From the cycle after a write to either register, `pin_oe` equals the inverse of direction and `pin_out` equals output data AND NOT direction. A line that is not driven shows 0 on `pin_out`.
- R3: When transition select (offset 0x0C) has a 1 for a line, a low-to-high change on that input line sets its bit in the status register (offset 0x14).
- R4: When transition select has a 0 for a line, a high-to-low change on that line sets its status bit, and a low-to-high change on that line does not.
- R5: A line whose mask bit (offset 0x10) is 1, or whose direction bit is 0, never sets its status bit.
- R6: A write to offset 0x14 clears each status bit written as 1 and leaves the other status bits unchanged. `irq` stays high until every status bit is 0.
- R7: `irq` is high in the cycle after any status bit becomes set.
- R8: A read of offset 0x00 returns the synchronized pin levels ANDed with the pin-enable register (offset 0x18). A pin change shows in this read two clock edges after it occurs.
- R9: Writes to offset 0x00 change nothing. Reads from any offset outside 0x00 to 0x18 return 0.
- R10: If a status bit's transition event and a write of 1 to that bit happen in the same cycle, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pin_in | input | 16 | Pin input levels, asynchronous |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is the cycle in which a new transition event and a clearing write land on the same status bit. The event appears only after the input has crossed both synchronizer stages, so the timing has to be arranged from the pin side. The stimulus first sets the bit and drops the pin, which produces no event. It then raises the pin and issues the clearing write exactly two edges later, so that both act at the same edge. The bit must still read as set afterwards.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   addr,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic         irq
);

  logic [N-1:0] sync1, sync2, prev;
  logic [N-1:0] dout, dir, edge_sel, mask, status, pin_en;
  logic [N-1:0] event_hit, clr;

  assign event_hit = ((edge_sel & sync2 & ~prev) | (~edge_sel & ~sync2 & prev)) & dir & ~mask;
  assign clr = (wr_en && addr == 8'h14) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1    <= '0;
      sync2    <= '0;
      prev     <= '0;
      dout     <= '1;
      dir      <= '1;
      edge_sel <= '1;
      mask     <= '1;
      status   <= '0;
      pin_en   <= '1;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      prev   <= sync2;
      status <= (status & ~clr) | event_hit;
      if (wr_en) begin
        case (addr)
          8'h04: dout     <= wdata;
          8'h08: dir      <= wdata;
          8'h0C: edge_sel <= wdata;
          8'h10: mask     <= wdata;
          8'h18: pin_en   <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      8'h00:   rdata = sync2 & pin_en;
      8'h04:   rdata = dout;
      8'h08:   rdata = dir;
      8'h0C:   rdata = edge_sel;
      8'h10:   rdata = mask;
      8'h14:   rdata = status;
      8'h18:   rdata = pin_en;
      default: rdata = '0;
    endcase
  end

  assign pin_oe  = ~dir;
  assign pin_out = dout & ~dir;
  assign irq     = |status;

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [7:0]   addr,
  input logic         wr_en,
  input logic [N-1:0] rdata,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic         irq
);

  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == 8'h14)) |=> irq);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr inside {8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18}) |-> rdata == '0);

  a_r2_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r5_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && &pin_oe) |=> !irq);

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rdata(rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic        wr_en = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [15:0] pin_in = 0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_check("R1", 8'h00, 16'h0000);
    rd_check("R1", 8'h04, 16'hFFFF);
    rd_check("R1", 8'h08, 16'hFFFF);
    rd_check("R1", 8'h0C, 16'hFFFF);
    rd_check("R1", 8'h10, 16'hFFFF);
    rd_check("R1", 8'h14, 16'h0000);
    rd_check("R1", 8'h18, 16'hFFFF);
    check("R1", pin_oe, 16'h0000);
    check("R1", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_direction();
    wr(8'h04, 16'h00A5);
    wr(8'h08, 16'hFF00);
    check("R2", pin_oe, 16'h00FF);
    check("R2", pin_out, 16'h00A5);
    wr(8'h08, 16'hFFF0);
    check("R2", pin_oe, 16'h000F);
    check("R2", pin_out, 16'h0005);
    wr(8'h08, 16'hFFFF);
    check("R2", pin_oe, 16'h0000);
    check("R2", pin_out, 16'h0000);
  endtask

  task automatic t_input_read();
    @(negedge clk); pin_in = 16'h1234; addr = 8'h00;
    @(negedge clk); #1; check("R8", rdata, 16'h0000);
    @(negedge clk); #1; check("R8", rdata, 16'h1234);
    wr(8'h18, 16'h00FF);
    rd_check("R8", 8'h00, 16'h0034);
    wr(8'h00, 16'hFFFF);
    rd_check("R9", 8'h00, 16'h0034);
    rd_check("R9", 8'h04, 16'h00A5);
    rd_check("R9", 8'h1C, 16'h0000);
    rd_check("R9", 8'h40, 16'h0000);
    wr(8'h18, 16'hFFFF);
    @(negedge clk); pin_in = 16'h0000;
    settle();
    rd_check("R5", 8'h14, 16'h0000);
  endtask

  task automatic t_rising();
    wr(8'h10, 16'hFFFE);
    @(negedge clk); pin_in[0] = 1;
    settle();
    rd_check("R3", 8'h14, 16'h0001);
    check("R7", {15'd0, irq}, 16'd1);
    wr(8'h14, 16'h0001);
    rd_check("R6", 8'h14, 16'h0000);
    check("R6", {15'd0, irq}, 16'd0);
    @(negedge clk); pin_in[0] = 0;
    settle();
    rd_check("R3", 8'h14, 16'h0000);
  endtask

  task automatic t_falling();
    wr(8'h0C, 16'hFFFD);
    wr(8'h10, 16'hFFFC);
    @(negedge clk); pin_in[1] = 1;
    settle();
    rd_check("R4", 8'h14, 16'h0000);
    @(negedge clk); pin_in[1] = 0;
    settle();
    rd_check("R4", 8'h14, 16'h0002);
    @(negedge clk); pin_in[0] = 1;
    settle();
    rd_check("R3", 8'h14, 16'h0003);
    wr(8'h14, 16'h0001);
    rd_check("R6", 8'h14, 16'h0002);
    check("R6", {15'd0, irq}, 16'd1);
    wr(8'h14, 16'h0002);
    rd_check("R6", 8'h14, 16'h0000);
    check("R6", {15'd0, irq}, 16'd0);
    @(negedge clk); pin_in[0] = 0;
    settle();
  endtask

  task automatic t_blocked();
    @(negedge clk); pin_in[2] = 1;
    settle();
    @(negedge clk); pin_in[2] = 0;
    settle();
    rd_check("R5", 8'h14, 16'h0000);
    wr(8'h08, 16'hFFFE);
    @(negedge clk); pin_in[0] = 1;
    settle();
    rd_check("R5", 8'h14, 16'h0000);
    check("R5", {15'd0, irq}, 16'd0);
    wr(8'h08, 16'hFFFF);
    @(negedge clk); pin_in[0] = 0;
    settle();
    rd_check("R5", 8'h14, 16'h0000);
  endtask

  task automatic t_collision();
    @(negedge clk); pin_in[0] = 1;
    settle();
    rd_check("R10", 8'h14, 16'h0001);
    @(negedge clk); pin_in[0] = 0;
    settle();
    @(negedge clk); pin_in[0] = 1;
    @(negedge clk);
    @(negedge clk); addr = 8'h14; wdata = 16'h0001; wr_en = 1;
    @(negedge clk); wr_en = 0;
    #1; check("R10", rdata, 16'h0001);
    check("R10", {15'd0, irq}, 16'd1);
    wr(8'h14, 16'hFFFF);
    rd_check("R6", 8'h14, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direction();
    t_input_read();
    t_rising();
    t_falling();
    t_blocked();
    t_collision();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule